// File: doc/BRIEF.md
# Square-Wave Clock-Out Timer

This block is a free-running up-counter that reloads itself from a programmable value each time it wraps past its maximum. Every wrap flips a divide-by-two flip-flop, so the block produces a square wave whose frequency is the tick rate divided by 2 × (65536 − reload). Counting advances only on cycles where the tick strobe is high, and only while the run enable is set. The tick strobe is expected to come from a fixed prescaler that fires once every two oscillator clocks. The square wave reaches the output pin only while the output enable is set.

A second, independent path watches a synchronized external trigger input. When the external enable is set, a high-to-low transition on that input latches a flag. The flag is the block's interrupt request and stays set until software clears it. Counter wraps never raise the interrupt.

Software loads the counter and the reload value one byte at a time through a simple write port. There is no data stream here. All pins are plain level or strobe controls with no valid/ready handshake, and nothing at the edge of the block applies back-pressure.

Top module: `sqwave_reload_timer`

## Requirements
- R1: After reset the counter and the reload value are zero, and `wave_pin`, `ext_flag` and `irq` are low.
- R2: On a cycle with `run` and `tick` both high, the counter increases by one. On any other cycle with no counter write, it keeps its value.
- R3: While `run` is low, ticks change neither the counter nor the square-wave level.
- R4: A tick that finds the counter at FFFFh loads the reload value into the counter in place of incrementing it.
- R5: Each reload caused by a tick toggles the square wave, giving one full output period every 2 × (65536 − reload) ticks.
- R6: `wave_pin` is low while `out_en` is low. The internal square wave keeps toggling during that time and shows again as soon as `out_en` returns high.
- R7: With a reload value of FFFFh the square wave toggles on every tick, which gives the highest output frequency of tick/2.
- R8: Writes use `wr_sel` as follows: 0 = counter bits 7:0, 1 = counter bits 15:8, 2 = reload bits 7:0, 3 = reload bits 15:8. Only the selected byte changes. A counter write takes effect at the next clock edge and overrides a tick in the same cycle.
- R9: With `ext_en` high, a falling edge on `ext_pin` sets `ext_flag` at the next clock edge, and `irq` follows `ext_flag`. A rising edge does not set the flag.
- R10: With `ext_en` low, a falling edge on `ext_pin` leaves `ext_flag` clear.
- R11: `ext_flag` stays set until a `flag_clr` pulse clears it. If a qualifying falling edge arrives in the same cycle as `flag_clr`, the flag remains set.
- R12: Counter reloads never set `ext_flag` or `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one cycle wide |
| run | input | 1 | Count enable |
| out_en | input | 1 | Drive the square wave onto `wave_pin` |
| ext_en | input | 1 | Arm the falling-edge detector on `ext_pin` |
| ext_pin | input | 1 | Synchronized external trigger |
| flag_clr | input | 1 | Clear `ext_flag` |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte select (see R8) |
| wr_data | input | 8 | Byte to write |
| wave_pin | output | 1 | Gated square-wave output |
| ext_flag | output | 1 | Latched external-edge flag |
| irq | output | 1 | Interrupt request |
| count | output | 16 | Current counter value |

## Verification
On every cycle the assertions check four things: the increment, the reload at FFFFh together with its toggle of the square wave, the freeze while stopped, and the flag's rules. The flag rules are that it holds until cleared, that it is set only with `ext_en` high, and that it sets after a qualifying edge. The assertions also check that the pin stays low while `out_en` is low. Some behaviour can only be shown by the bench's scenarios. This covers the full output period for a given reload, the fastest toggle rate, byte-select decoding and write priority over a tick, and the reappearance of the hidden wave when `out_en` returns high.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
  localparam int BYTE_W = 8;

  // top bit of the byte select picks the register bank
  typedef enum logic {
    BANK_COUNT  = 1'b0,
    BANK_RELOAD = 1'b1
  } bank_e;
endpackage

// File: rtl/sqt_counter.sv
module sqt_counter #(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      run,
  input  logic                      cnt_wr,
  input  logic                      rld_wr,
  input  logic [$clog2(W/8)-1:0]    byte_idx,
  input  logic [7:0]                wr_data,
  output logic [W-1:0]              cnt_q,
  output logic [W-1:0]              rld_q,
  output logic                      wrap
);
  import sqt_pkg::*;
  localparam int NB = W / BYTE_W;
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_d, rld_d;

  assign wrap = run && tick && !cnt_wr && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr) begin
      for (int i = 0; i < NB; i++)
        if (byte_idx == i[$clog2(W/8)-1:0]) cnt_d[i*BYTE_W +: BYTE_W] = wr_data;
    end else if (run && tick) begin
      cnt_d = (cnt_q == TOP) ? rld_q : cnt_q + W'(1);
    end
  end

  always_comb begin
    rld_d = rld_q;
    if (rld_wr)
      for (int i = 0; i < NB; i++)
        if (byte_idx == i[$clog2(W/8)-1:0]) rld_d[i*BYTE_W +: BYTE_W] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end
endmodule

// File: rtl/sqt_divider.sv
module sqt_divider (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic out_en,
  output logic wave_q,
  output logic wave_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)      wave_q <= 1'b0;
    else if (toggle) wave_q <= ~wave_q;
  end

  assign wave_out = out_en & wave_q;
endmodule

// File: rtl/sqt_edge_flag.sv
module sqt_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic arm,
  input  logic clr,
  output logic flag_q
);
  logic prev_q;
  logic hit;

  assign hit = arm && prev_q && !pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin;
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sqwave_reload_timer.sv
module sqwave_reload_timer #(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   run,
  input  logic                   out_en,
  input  logic                   ext_en,
  input  logic                   ext_pin,
  input  logic                   flag_clr,
  input  logic                   wr_en,
  input  logic [$clog2(W/8):0]   wr_sel,
  input  logic [7:0]             wr_data,
  output logic                   wave_pin,
  output logic                   ext_flag,
  output logic                   irq,
  output logic [W-1:0]           count
);
  import sqt_pkg::*;
  localparam int IDXW = $clog2(W/8);

  logic          cnt_wr, rld_wr, wrap, wave_raw;
  logic [W-1:0]  rld_val;
  bank_e         bank;

  assign bank   = bank_e'(wr_sel[IDXW]);
  assign cnt_wr = wr_en && (bank == BANK_COUNT);
  assign rld_wr = wr_en && (bank == BANK_RELOAD);

  sqt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .cnt_wr(cnt_wr), .rld_wr(rld_wr), .byte_idx(wr_sel[IDXW-1:0]),
    .wr_data(wr_data), .cnt_q(count), .rld_q(rld_val), .wrap(wrap)
  );

  sqt_divider u_div (
    .clk(clk), .rst_n(rst_n), .toggle(wrap), .out_en(out_en),
    .wave_q(wave_raw), .wave_out(wave_pin)
  );

  sqt_edge_flag u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .arm(ext_en),
    .clr(flag_clr), .flag_q(ext_flag)
  );

  assign irq = ext_flag;
endmodule

// File: rtl/sqwave_reload_timer_chk.sv
module sqwave_reload_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic         out_en,
  input logic         ext_en,
  input logic         ext_pin,
  input logic         flag_clr,
  input logic         wr_en,
  input logic         ext_flag,
  input logic         wave_pin,
  input logic         wave_raw,
  input logic [W-1:0] count,
  input logic [W-1:0] rld_val
);
  localparam logic [W-1:0] TOP = '1;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_en && count != TOP) |=> count == $past(count) + W'(1));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> ($stable(count) && $stable(wave_raw)));

  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_en && count == TOP) |=> count == $past(rld_val));

  // R5
  wrap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_en && count == TOP) |=> wave_raw != $past(wave_raw));

  // R6
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !wave_pin);

  // R9
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && !ext_pin && $past(ext_pin)) |-> ##0 1'b1 ##1 ext_flag);

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag && !flag_clr) |=> ext_flag);

  // R10
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(ext_en));
endmodule

bind sqwave_reload_timer sqwave_reload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .out_en(out_en),
  .ext_en(ext_en), .ext_pin(ext_pin), .flag_clr(flag_clr), .wr_en(wr_en),
  .ext_flag(ext_flag), .wave_pin(wave_pin), .wave_raw(wave_raw),
  .count(count), .rld_val(rld_val)
);

// File: tb/sqwave_reload_timer_test.sv
module sqwave_reload_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, run = 0, out_en = 0, ext_en = 0, ext_pin = 1, flag_clr = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic wave_pin, ext_flag, irq;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sqwave_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .out_en(out_en),
    .ext_en(ext_en), .ext_pin(ext_pin), .flag_clr(flag_clr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .wave_pin(wave_pin),
    .ext_flag(ext_flag), .irq(irq), .count(count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic set_rld(input logic [15:0] v);
    wr(2'd2, v[7:0]); wr(2'd3, v[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 wave", wave_pin, 0);
    chk("R1 flag", ext_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_count;
    set_cnt(16'h0010);
    chk("R8 count load", count, 16'h0010);
    run = 1;
    ticks(5);
    chk("R2 five ticks", count, 16'h0015);
    repeat (4) @(negedge clk);
    chk("R2 no tick hold", count, 16'h0015);
  endtask

  task automatic t_freeze;
    run = 0;
    ticks(3);
    chk("R3 frozen count", count, 16'h0015);
    chk("R3 frozen wave", wave_pin, 0);
    run = 1;
  endtask

  task automatic t_priority;
    set_cnt(16'h1200);
    @(negedge clk); tick = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 8'h34;
    @(negedge clk); tick = 0; wr_en = 0;
    chk("R8 write beats tick", count, 16'h1234);
    wr(2'd3, 8'hAB);
    chk("R8 reload write leaves count", count, 16'h1234);
  endtask

  task automatic t_overflow;
    out_en = 1;
    set_rld(16'hFFF0);
    set_cnt(16'hFFFE);
    ticks(1);
    chk("R2 to top", count, 16'hFFFF);
    ticks(1);
    chk("R4 reload", count, 16'hFFF0);
    chk("R5 first toggle", wave_pin, 1);
    ticks(15);
    chk("R5 half period hold", wave_pin, 1);
    chk("R5 count at top", count, 16'hFFFF);
    ticks(1);
    chk("R5 second toggle", wave_pin, 0);
    chk("R12 no irq on wrap", irq, 0);
  endtask

  task automatic t_outen;
    out_en = 0;
    ticks(16);
    chk("R6 pin gated", wave_pin, 0);
    @(negedge clk); out_en = 1;
    #1;
    chk("R6 pin restored", wave_pin, 1);
  endtask

  task automatic t_fastest;
    set_rld(16'hFFFF);
    set_cnt(16'hFFFF);
    ticks(1);
    chk("R7 toggle 1", wave_pin, 0);
    chk("R7 count stays", count, 16'hFFFF);
    ticks(1);
    chk("R7 toggle 2", wave_pin, 1);
    ticks(1);
    chk("R7 toggle 3", wave_pin, 0);
    chk("R12 flag clear", ext_flag, 0);
    run = 0;
  endtask

  task automatic t_ext;
    ext_en = 1;
    @(negedge clk); ext_pin = 0;
    @(negedge clk);
    chk("R9 fall sets flag", ext_flag, 1);
    chk("R9 irq follows", irq, 1);
    repeat (5) @(negedge clk);
    chk("R11 flag held", ext_flag, 1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk("R11 cleared", ext_flag, 0);
    @(negedge clk); ext_pin = 1;
    @(negedge clk);
    chk("R9 rise ignored", ext_flag, 0);
    @(negedge clk); ext_pin = 0; flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk("R11 set beats clear", ext_flag, 1);
    @(negedge clk); flag_clr = 1; ext_pin = 1;
    @(negedge clk); flag_clr = 0; ext_en = 0;
    @(negedge clk); ext_pin = 0;
    @(negedge clk);
    chk("R10 disarmed fall ignored", ext_flag, 0);
    chk("R10 irq low", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_count;
    t_freeze;
    t_priority;
    t_overflow;
    t_outen;
    t_fastest;
    t_ext;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule